// File: doc/BRIEF.md
# Clock Ratio Detector and Monitor

This block measures how many master-clock cycles fit into one period of a frame clock and decides whether the ratio is 256, 384 or 512. The frame clock arrives without a timing relationship the block can rely on, so it is first brought into the master-clock domain. Each rising edge of the synchronized frame clock then closes one measurement.

A legal measurement only becomes a lock when the next measurement agrees with it. After lock the block keeps measuring every frame. The first frame whose length differs from the locked value raises a one-cycle resync pulse, drops the lock and starts detection again. A frame clock that stops entirely is handled the same way. The lock can fail because the frequency changed, or because a phase jump shortened or stretched a single frame.

The divider-select output tells the downstream clock generator by how much to divide the master clock to reach 128 times the frame rate. The ratio code and the lock flag report the detected ratio to the rest of the chip.

Top module: `clk_ratio_monitor`

## Requirements
- R1: While `rst` is high, and after it is released until a lock is reached, `ratio_code_o` is 2'b11, `locked_o` is 0, `div_sel_o` is 0 and `resync_o` is 0.
- R2: The period is the number of `mclk` rising edges between two consecutive rising edges of the frame clock, after the frame clock has passed a two-flop synchronizer. Periods of 256, 384 and 512 map to codes 2'b00, 2'b01 and 2'b10. Every other period is illegal.
- R3: The first frame edge after reset only starts a measurement. `locked_o` rises only after two consecutive measured periods carry the same legal value, which means no earlier than the third frame edge.
- R4: An illegal period never leads to lock and never raises `resync_o`. Detection starts over, so two new matching legal periods are needed.
- R5: While locked, `div_sel_o` equals the ratio divided by 128: 2 for 256, 3 for 384 and 4 for 512. While unlocked it is 0.
- R6: While locked, a measured period that differs from the locked one raises `resync_o`, clears `locked_o` and returns `ratio_code_o` to 2'b11. This applies to a frequency change and to a phase jump alike.
- R7: If no frame edge arrives within `OVF_LIMIT` (default 520) cycles of the previous one, the period counts as illegal. When locked, this raises `resync_o` without waiting for the next frame edge.
- R8: `resync_o` is exactly one cycle wide and is raised only when leaving the locked state.
- R9: After a resync, the period that caused it is not reused as a candidate. Two fresh matching legal periods are needed to lock again.
- R10: While a candidate awaits confirmation, a different legal period replaces the candidate without locking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_in | input | 1 | Frame clock, asynchronous to the block's sampling |
| ratio_code_o | output | 2 | 00=256, 01=384, 10=512, 11=unlocked |
| locked_o | output | 1 | Ratio confirmed and still holding |
| div_sel_o | output | 3 | Master-clock divider for 128x frame rate; 0 when unlocked |
| resync_o | output | 1 | One-cycle pulse when the lock is lost |

## Verification
Several properties are checked on every cycle:
- The code, lock and divider outputs stay consistent with each other.
- The resync pulse lasts one cycle and happens only on leaving lock.
- A lock only appears two cycles after a synchronized frame edge.
- No lock survives a frame-edge gap beyond the overflow limit.

Other behaviour only the directed scenarios can show:
- The exact frame on which lock is first declared.
- That an illegal or replaced candidate delays the lock.
- That the period causing a resync is not reused.
- That frequency switches, a single shortened frame and a stopped frame clock each cost exactly one resync.

// File: rtl/clkrat_pkg.sv
package clkrat_pkg;

    localparam int unsigned RATIO_LO  = 256;
    localparam int unsigned RATIO_MID = 384;
    localparam int unsigned RATIO_HI  = 512;
    localparam int unsigned CNT_W     = 10;

    typedef enum logic [1:0] {
        CODE_256  = 2'b00,
        CODE_384  = 2'b01,
        CODE_512  = 2'b10,
        CODE_NONE = 2'b11
    } ratio_code_e;

    typedef enum logic [1:0] {
        TRK_SEEK    = 2'b00,
        TRK_CONFIRM = 2'b01,
        TRK_LOCKED  = 2'b10
    } trk_state_e;

    typedef struct packed {
        logic             valid;
        logic             ovf;
        logic [CNT_W-1:0] cycles;
    } period_meas_t;

    // Map a measured period onto a ratio code; anything else is illegal.
    function automatic ratio_code_e classify(input logic [CNT_W-1:0] c);
        ratio_code_e r;
        if (c == CNT_W'(RATIO_LO))       r = CODE_256;
        else if (c == CNT_W'(RATIO_MID)) r = CODE_384;
        else if (c == CNT_W'(RATIO_HI))  r = CODE_512;
        else                             r = CODE_NONE;
        return r;
    endfunction

    // Divider that brings the master clock to 128x the frame rate.
    function automatic logic [2:0] divider_for(input ratio_code_e c);
        logic [2:0] d;
        case (c)
            CODE_256: d = 3'd2;
            CODE_384: d = 3'd3;
            CODE_512: d = 3'd4;
            default:  d = 3'd0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/frame_sync.sv
module frame_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain;
    logic              last;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= chain[STAGES-1];
    end

    assign rise_o = chain[STAGES-1] & ~last;

endmodule

// File: rtl/period_meter.sv
module period_meter
    import clkrat_pkg::*;
#(
    parameter int unsigned OVF_LIMIT = 520
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         edge_i,
    output period_meas_t meas_o
);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(OVF_LIMIT);
    localparam logic [CNT_W-1:0] SAT_V   = CNT_W'(OVF_LIMIT + 1);

    logic [CNT_W-1:0] cnt;
    logic             seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            seen   <= 1'b0;
            meas_o <= '0;
        end else begin
            meas_o.valid <= edge_i & seen;
            meas_o.ovf   <= 1'b0;
            if (edge_i) begin
                meas_o.cycles <= cnt;
                cnt           <= CNT_W'(1);
                seen          <= 1'b1;
            end else begin
                if (cnt != SAT_V) cnt <= cnt + 1'b1;
                if (seen && cnt == LIMIT_V) meas_o.ovf <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ratio_tracker.sv
module ratio_tracker
    import clkrat_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  period_meas_t meas_i,
    output logic [1:0]   code_o,
    output logic         locked_o,
    output logic [2:0]   div_o,
    output logic         resync_o
);
    trk_state_e  state;
    ratio_code_e cand;
    ratio_code_e cls;
    logic        legal;

    assign cls   = classify(meas_i.cycles);
    assign legal = (cls != CODE_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= TRK_SEEK;
            cand     <= CODE_NONE;
            resync_o <= 1'b0;
        end else begin
            resync_o <= 1'b0;
            case (state)
                TRK_SEEK: begin
                    if (meas_i.valid && legal) begin
                        cand  <= cls;
                        state <= TRK_CONFIRM;
                    end
                end
                TRK_CONFIRM: begin
                    if (meas_i.ovf) begin
                        state <= TRK_SEEK;
                    end else if (meas_i.valid) begin
                        if (!legal)            state <= TRK_SEEK;
                        else if (cls == cand)  state <= TRK_LOCKED;
                        else                   cand  <= cls;
                    end
                end
                TRK_LOCKED: begin
                    if (meas_i.ovf || (meas_i.valid && cls != cand)) begin
                        resync_o <= 1'b1;
                        state    <= TRK_SEEK;
                    end
                end
                default: state <= TRK_SEEK;
            endcase
        end
    end

    assign locked_o = (state == TRK_LOCKED);
    assign code_o   = locked_o ? cand : CODE_NONE;
    assign div_o    = divider_for(ratio_code_e'(code_o));

endmodule

// File: rtl/clk_ratio_monitor.sv
module clk_ratio_monitor
    import clkrat_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned OVF_LIMIT   = 520
) (
    input  logic       mclk,
    input  logic       rst,
    input  logic       frame_in,
    output logic [1:0] ratio_code_o,
    output logic       locked_o,
    output logic [2:0] div_sel_o,
    output logic       resync_o
);
    logic         frame_rise;
    period_meas_t meas;

    frame_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (mclk),
        .rst     (rst),
        .async_i (frame_in),
        .rise_o  (frame_rise)
    );

    period_meter #(.OVF_LIMIT(OVF_LIMIT)) u_meter (
        .clk    (mclk),
        .rst    (rst),
        .edge_i (frame_rise),
        .meas_o (meas)
    );

    ratio_tracker u_track (
        .clk      (mclk),
        .rst      (rst),
        .meas_i   (meas),
        .code_o   (ratio_code_o),
        .locked_o (locked_o),
        .div_o    (div_sel_o),
        .resync_o (resync_o)
    );

endmodule

// File: rtl/clk_ratio_checker.sv
module clk_ratio_checker #(
    parameter int unsigned OVF_LIMIT = 520
) (
    input logic       clk,
    input logic       rst,
    input logic       frame_rise,
    input logic       locked,
    input logic [1:0] ratio_code,
    input logic [2:0] div_sel,
    input logic       resync
);
    logic [10:0] gap;

    always_ff @(posedge clk) begin
        if (rst || frame_rise) gap <= '0;
        else if (gap != 11'h7FF) gap <= gap + 1'b1;
    end

    // R1: unlocked means code 11 and no divider
    p_unlocked_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !locked |-> (ratio_code == 2'b11 && div_sel == 3'd0));

    // R5: divider follows the locked code
    p_divider_r5: assert property (@(posedge clk) disable iff (rst)
        locked |-> (ratio_code != 2'b11 && div_sel == {1'b0, ratio_code} + 3'd2));

    // R3: lock appears two cycles after a synchronized frame edge
    p_lock_on_edge_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(frame_rise, 2));

    // R6: the locked code does not drift while lock holds
    p_code_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (locked && $past(locked)) |-> $stable(ratio_code));

    // R8: resync only on leaving lock
    p_resync_exit_r8: assert property (@(posedge clk) disable iff (rst)
        resync |-> ($past(locked) && !locked));

    // R8: resync is a single cycle
    p_resync_single_r8: assert property (@(posedge clk) disable iff (rst)
        resync |=> !resync);

    // R7: no lock survives a gap well beyond the limit
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (gap >= 11'(OVF_LIMIT + 8)) |-> !locked);

endmodule

bind clk_ratio_monitor clk_ratio_checker #(.OVF_LIMIT(OVF_LIMIT)) u_chk (
    .clk        (mclk),
    .rst        (rst),
    .frame_rise (frame_rise),
    .locked     (locked_o),
    .ratio_code (ratio_code_o),
    .div_sel    (div_sel_o),
    .resync     (resync_o)
);

// File: tb/sim_clk_ratio_monitor.sv
`timescale 1ns/1ps
module sim_clk_ratio_monitor;
    logic       mclk = 1'b0;
    logic       rst  = 1'b1;
    logic       frame_in = 1'b0;
    logic [1:0] ratio_code;
    logic       locked;
    logic [2:0] div_sel;
    logic       resync;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int run = 0;
    int max_run = 0;
    bit done = 1'b0;

    clk_ratio_monitor u0 (
        .mclk         (mclk),
        .rst          (rst),
        .frame_in     (frame_in),
        .ratio_code_o (ratio_code),
        .locked_o     (locked),
        .div_sel_o    (div_sel),
        .resync_o     (resync)
    );

    always #2.5 mclk = ~mclk;

    always @(negedge mclk) begin
        if (resync) begin
            pulses++;
            run++;
            if (run > max_run) max_run = run;
        end else begin
            run = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        frame_in = 1'b0;
        repeat (4) @(negedge mclk);
        rst = 1'b0;
        @(negedge mclk);
    endtask

    // One frame of n cycles, starting with its rising edge; called at a negedge.
    task automatic frame(input int n);
        frame_in = 1'b1;
        repeat (n / 2) @(negedge mclk);
        frame_in = 1'b0;
        repeat (n - n / 2) @(negedge mclk);
    endtask

    task automatic expect_lock(input string req, input int code, input int div);
        chk({req, " locked"}, locked, 1);
        chk({req, " code"}, ratio_code, code);
        chk({req, " div"}, div_sel, div);
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        repeat (3) @(negedge mclk);
        chk("R1 code in reset", ratio_code, 3);
        chk("R1 lock in reset", locked, 0);
        chk("R1 div in reset", div_sel, 0);
        chk("R1 resync in reset", resync, 0);
        do_reset();
        chk("R1 code after reset", ratio_code, 3);
    endtask

    task automatic t_lock_256();
        frame(256);
        chk("R3 no lock after first edge", locked, 0);
        frame(256);
        chk("R3 no lock after one period", locked, 0);
        frame(256);
        expect_lock("R2 R5 256", 0, 2);
    endtask

    task automatic t_switch(input int n, input int code, input int div);
        int p0;
        p0 = pulses;
        frame(n);
        chk("R6 still locked on old period", locked, 1);
        frame(n);
        chk("R6 lock dropped on change", locked, 0);
        chk("R6 code back to none", ratio_code, 3);
        chk("R6 one resync", pulses - p0, 1);
        frame(n);
        chk("R9 no reuse of failing period", locked, 0);
        frame(n);
        expect_lock("R2 R5 R9 relock", code, div);
    endtask

    task automatic t_gap();
        int p0;
        p0 = pulses;
        repeat (700) @(negedge mclk);
        chk("R7 lock lost on gap", locked, 0);
        chk("R7 resync on gap", pulses - p0, 1);
        frame(256);
        frame(256);
        chk("R7 saturated period not used", locked, 0);
        frame(256);
        expect_lock("R7 relock after gap", 0, 2);
    endtask

    task automatic t_phase();
        int p0;
        p0 = pulses;
        frame(200);
        frame(256);
        chk("R6 phase jump drops lock", locked, 0);
        chk("R6 phase jump resync", pulses - p0, 1);
    endtask

    task automatic t_illegal();
        int p0;
        do_reset();
        p0 = pulses;
        repeat (5) frame(300);
        chk("R4 no lock on 300", locked, 0);
        frame(256);
        frame(300);
        frame(256);
        frame(384);
        chk("R4 no lock on alternating", locked, 0);
        chk("R4 no resync when unlocked", pulses - p0, 0);
        frame(384);
        chk("R4 one legal period not enough", locked, 0);
        frame(384);
        expect_lock("R4 lock after two legal", 1, 3);
    endtask

    task automatic t_replace();
        do_reset();
        frame(256);
        frame(384);
        chk("R10 candidate pending", locked, 0);
        frame(384);
        chk("R10 replaced candidate not locked", locked, 0);
        frame(256);
        expect_lock("R10 lock on new candidate", 1, 3);
    endtask

    initial begin
        t_reset_state();
        t_lock_256();
        t_switch(384, 1, 3);
        t_switch(512, 2, 4);
        t_gap();
        t_phase();
        t_illegal();
        t_replace();
        chk("R8 resync width", max_run, 1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge mclk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule